// File: doc/BRIEF.md
# Watchdog Timer with Timed Change Protection

This block is a watchdog timer clocked by its own oscillator. Once armed, a counter advances every cycle. If nothing clears it before it reaches the selected timeout, the block raises a one-cycle reset request and the counter starts again from zero. Software keeps the system alive by pulsing the kick input. The timeout and the arm state are held in a single 8-bit control register. Software writes it with a one-cycle write strobe and reads it back on a plain read bus.

Two operations are guarded by a timed unlock: turning the watchdog off, and (at guarded levels) changing the timeout.

- An unlock write sets the unlock bit and the enable bit together.
- This opens a window of four clock edges. During the window the real write can clear enable or load a new timeout code.
- A static protection-level input chooses how strict the block is. At the strictest levels the watchdog can never be switched off once it is armed.

Top module: `wdog_guard`

## Requirements
- R1: After reset the control register reads 0x00 and the reset request output is low.
- R2: Bits 7 to 5 of the control register always read zero, whatever value is written to them.
- R3: A write with bit 3 (enable) at one arms the watchdog at every protection level, with no unlock needed.
- R4: A write with bit 4 (unlock) and bit 3 both at one opens the unlock window. Bit 4 then reads one after that write edge and after the next three edges, and reads zero after the fourth edge. A write that only sets bit 4 does not open the window.
- R5: A write that clears bit 3 outside the window leaves enable unchanged, while the other writable fields that are unguarded still take the written value.
- R6: At protection levels 0 and 1, a write that clears bit 3 on any of the four edges after the unlock write disarms the watchdog. The same write on the fifth edge or later is ignored.
- R7: At protection levels 2 and 3, enable cannot be cleared, even inside a live window.
- R8: At level 0 the timeout code in bits 2:0 takes every written value. At levels 1 to 3 it changes only on a write made while the window is live.
- R9: While armed, the reset request rises for exactly one cycle BASE_CYCLES x 2^code edges after the edge that armed the watchdog, or after the previous request. The counter then restarts from zero.
- R10: A kick clears the counter, so the next request comes a full timeout after the kick edge.
- R11: Disarming the watchdog clears the counter, and no request is raised while it is off.
- R12: Any write made while the window is live closes the window, unless that write is itself an unlock write, which restarts the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| safety_lvl | input | 2 | Static protection level: 0 open, 1 guarded timeout, 2 and 3 locked on |
| wr_en | input | 1 | One-cycle write strobe for the control register |
| wr_data | input | 8 | Write data: bit 4 unlock, bit 3 enable, bits 2:0 timeout code |
| rd_data | output | 8 | Current control register value, with bit 4 showing a live window |
| kick | input | 1 | Clears the timeout counter |
| wdt_rst | output | 1 | One-cycle reset request on timeout |

## Verification
The bench builds the block with BASE_CYCLES set to 4, so the eight timeout codes span 4 to 512 cycles. This makes the exact edge of a request, the effect of a kick partway through a period, and silence after disarm all cheap to observe cycle by cycle. The unlock window keeps its default of four edges. This lets the bench write on the last live edge and on the first expired edge, at every protection level, including the alias level 3.

// File: rtl/wdog_guard_pkg.sv
package wdog_guard_pkg;

    localparam int unsigned SEL_W = 3;

    // Control register layout (bit positions are software visible)
    typedef struct packed {
        logic [2:0]       rsvd;
        logic             unlock;
        logic             enable;
        logic [SEL_W-1:0] span_sel;
    } wdog_ctrl_t;

    typedef enum logic [1:0] {
        LVL_OPEN       = 2'd0,
        LVL_GUARDED    = 2'd1,
        LVL_LOCKED     = 2'd2,
        LVL_LOCKED_ALT = 2'd3
    } guard_lvl_e;

    // Timeout code is protected outside the window at every level but open
    function automatic logic span_guarded(input guard_lvl_e lvl);
        return lvl != LVL_OPEN;
    endfunction

    // Disarm permitted only at the two lower levels
    function automatic logic disarm_allowed(input guard_lvl_e lvl);
        return (lvl == LVL_OPEN) || (lvl == LVL_GUARDED);
    endfunction

    // Timeout length in oscillator cycles for a given code
    function automatic logic [31:0] span_cycles(input logic [31:0] base,
                                                input logic [SEL_W-1:0] code);
        return base << code;
    endfunction

endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
    import wdog_guard_pkg::*;
#(
    parameter int unsigned UNLOCK_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  guard_lvl_e       lvl,
    input  logic             wr_en,
    input  logic             wr_unlock,
    input  logic             wr_enable,
    input  logic [SEL_W-1:0] wr_sel,
    output logic             en_o,
    output logic [SEL_W-1:0] sel_o,
    output logic             live_o
);
    localparam int unsigned WIN_W = $clog2(UNLOCK_CYCLES + 1);

    logic [WIN_W-1:0] win_q;
    logic             en_q;
    logic [SEL_W-1:0] sel_q;
    logic             live;
    logic             opens;

    assign live  = (win_q != '0);
    assign opens = wr_en && wr_unlock && wr_enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
            en_q  <= 1'b0;
            sel_q <= '0;
        end else begin
            // Window: an unlock write (re)starts it, any other write closes it
            if (opens)
                win_q <= WIN_W'(UNLOCK_CYCLES);
            else if (wr_en)
                win_q <= '0;
            else if (live)
                win_q <= win_q - 1'b1;

            if (wr_en) begin
                if (wr_enable)
                    en_q <= 1'b1;
                else if (live && disarm_allowed(lvl))
                    en_q <= 1'b0;
                if (!span_guarded(lvl) || live)
                    sel_q <= wr_sel;
            end
        end
    end

    assign en_o   = en_q;
    assign sel_o  = sel_q;
    assign live_o = live;

    // R4: the window only opens because of an unlock write
    assert_window_opens_on_write_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(live) |-> $past(opens));

    // R6: disarm only happens through a write inside a live window
    assert_disarm_needs_window_R6: assert property (@(posedge clk) disable iff (rst)
        ($fell(en_q) && !$past(rst)) |-> ($past(live) && $past(wr_en)));

    // R7: locked levels keep an armed watchdog armed
    assert_locked_stays_on_R7: assert property (@(posedge clk) disable iff (rst)
        (!disarm_allowed(lvl) && en_q) |=> en_q);

    // R8: a guarded timeout code does not move while the window is closed
    assert_sel_guarded_R8: assert property (@(posedge clk) disable iff (rst)
        (span_guarded(lvl) && !live) |=> $stable(sel_q));

endmodule

// File: rtl/wdog_span_counter.sv
module wdog_span_counter
    import wdog_guard_pkg::*;
#(
    parameter int unsigned BASE_CYCLES = 16384
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             kick,
    input  logic [SEL_W-1:0] sel,
    output logic             bite
);
    localparam int unsigned CNT_W = $clog2(BASE_CYCLES) + (1 << SEL_W);

    logic [CNT_W-1:0] cnt_q;
    logic             bite_q;
    logic [CNT_W-1:0] last;

    assign last = CNT_W'(span_cycles(32'(BASE_CYCLES), sel) - 32'd1);

    always_ff @(posedge clk) begin
        if (rst || !en || kick) begin
            cnt_q  <= '0;
            bite_q <= 1'b0;
        end else if (cnt_q >= last) begin
            cnt_q  <= '0;
            bite_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            bite_q <= 1'b0;
        end
    end

    assign bite = bite_q;

    // R9: the request lasts a single cycle
    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (rst)
        bite_q |=> !bite_q);

    // R10: a kick restarts the count and suppresses the request
    assert_kick_clears_R10: assert property (@(posedge clk) disable iff (rst)
        kick |=> (cnt_q == '0) && !bite_q);

    // R11: nothing fires while disarmed
    assert_off_is_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !en |=> !bite_q && (cnt_q == '0));

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
    import wdog_guard_pkg::*;
#(
    parameter int unsigned BASE_CYCLES   = 16384,
    parameter int unsigned UNLOCK_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] safety_lvl,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       kick,
    output logic       wdt_rst
);
    wdog_ctrl_t       wr_word;
    wdog_ctrl_t       rd_word;
    guard_lvl_e       lvl;
    logic             en;
    logic             live;
    logic [SEL_W-1:0] sel;

    assign wr_word = wdog_ctrl_t'(wr_data);
    assign lvl     = guard_lvl_e'(safety_lvl);

    wdog_ctrl_reg #(
        .UNLOCK_CYCLES(UNLOCK_CYCLES)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .lvl      (lvl),
        .wr_en    (wr_en),
        .wr_unlock(wr_word.unlock),
        .wr_enable(wr_word.enable),
        .wr_sel   (wr_word.span_sel),
        .en_o     (en),
        .sel_o    (sel),
        .live_o   (live)
    );

    wdog_span_counter #(
        .BASE_CYCLES(BASE_CYCLES)
    ) u_count (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .kick(kick),
        .sel (sel),
        .bite(wdt_rst)
    );

    always_comb begin
        rd_word          = '0;
        rd_word.unlock   = live;
        rd_word.enable   = en;
        rd_word.span_sel = sel;
    end
    assign rd_data = rd_word;

    // R2: writing ones into the reserved bits never shows up on the read bus
    assert_rsvd_read_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_word.rsvd != 3'b000)) |=> (rd_data[7:5] == 3'b000));

endmodule

// File: tb/wdog_guard_bench.sv
module wdog_guard_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] safety_lvl = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       kick = 1'b0;
    logic       wdt_rst;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_guard #(.BASE_CYCLES(BASE), .UNLOCK_CYCLES(4)) u_wdog_guard (
        .clk(clk), .rst(rst), .safety_lvl(safety_lvl), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .kick(kick), .wdt_rst(wdt_rst)
    );

    typedef struct packed {
        logic       do_rst;
        logic [1:0] lvl;
        logic [3:0] idle;
        logic [7:0] wr;
        logic [7:0] exp;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd0, 4'd0, 8'hE0, 8'h00, 8'd2},  // R2 reserved bits
        '{1'b0, 2'd0, 4'd0, 8'h0D, 8'h0D, 8'd3},  // R3 arm, R8 free code
        '{1'b0, 2'd0, 4'd0, 8'h02, 8'h0A, 8'd5},  // R5 clear ignored, code moves
        '{1'b0, 2'd0, 4'd0, 8'h1A, 8'h1A, 8'd4},  // R4 unlock
        '{1'b0, 2'd0, 4'd2, 8'h03, 8'h03, 8'd6},  // R6 disarm in window
        '{1'b0, 2'd0, 4'd0, 8'h08, 8'h08, 8'd3},  // R3
        '{1'b0, 2'd0, 4'd0, 8'h18, 8'h18, 8'd4},  // R4
        '{1'b0, 2'd0, 4'd4, 8'h00, 8'h08, 8'd6},  // R6 fifth edge ignored
        '{1'b0, 2'd0, 4'd0, 8'h18, 8'h18, 8'd4},  // R4
        '{1'b0, 2'd0, 4'd3, 8'h00, 8'h00, 8'd6},  // R6 fourth edge accepted
        '{1'b1, 2'd1, 4'd0, 8'h0B, 8'h08, 8'd8},  // R8 guarded code held
        '{1'b0, 2'd1, 4'd0, 8'h1B, 8'h18, 8'd8},  // R8 unlock write itself not live
        '{1'b0, 2'd1, 4'd0, 8'h0B, 8'h0B, 8'd8},  // R8 code loads in window
        '{1'b0, 2'd1, 4'd0, 8'h0C, 8'h0B, 8'd12}, // R12 window closed by last write
        '{1'b0, 2'd1, 4'd0, 8'h1B, 8'h1B, 8'd4},  // R4
        '{1'b0, 2'd1, 4'd0, 8'h03, 8'h03, 8'd6},  // R6 level 1 disarm
        '{1'b1, 2'd2, 4'd0, 8'h08, 8'h08, 8'd3},  // R3 level 2 arm
        '{1'b0, 2'd2, 4'd0, 8'h18, 8'h18, 8'd4},  // R4
        '{1'b0, 2'd2, 4'd0, 8'h05, 8'h0D, 8'd7},  // R7 stays on, code loads
        '{1'b0, 2'd2, 4'd0, 8'h00, 8'h0D, 8'd7},  // R7
        '{1'b0, 2'd2, 4'd0, 8'h18, 8'h1D, 8'd12}, // R12 reopen, code held
        '{1'b0, 2'd2, 4'd0, 8'h10, 8'h08, 8'd7},  // R7 no disarm; bit4 alone no reopen
        '{1'b1, 2'd3, 4'd0, 8'h08, 8'h08, 8'd3},  // R3 level 3
        '{1'b0, 2'd3, 4'd0, 8'h18, 8'h18, 8'd4},  // R4
        '{1'b0, 2'd3, 4'd0, 8'h00, 8'h08, 8'd7}   // R7 alias level
    };

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
    endtask

    task automatic write_reg(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        step();
        wr_en   = 1'b0;
        wr_data = 8'h00;
    endtask

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        step();
        do_reset();
        check(rd_data, 8'h00, "R1");
        check({7'd0, wdt_rst}, 8'h00, "R1");

        // Register vectors
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].do_rst) begin
                safety_lvl = VECS[i].lvl;
                do_reset();
            end
            repeat (VECS[i].idle) step();
            write_reg(VECS[i].wr);
            check(rd_data, VECS[i].exp, $sformatf("R%0d vec %0d", VECS[i].req, i));
        end

        // R4: unlock bit visible for four edges
        safety_lvl = 2'd0;
        do_reset();
        write_reg(8'h18);
        for (int k = 0; k <= 4; k++) begin
            check({7'd0, rd_data[4]}, (k < 4) ? 8'h01 : 8'h00, "R4 window length");
            step();
        end

        // R9: code 0 gives 4 cycles, requests repeat
        do_reset();
        write_reg(8'h08);
        for (int k = 1; k <= 9; k++) begin
            step();
            check({7'd0, wdt_rst}, (k == 4 || k == 8) ? 8'h01 : 8'h00, "R9 code0");
        end

        // R9: code 2 gives 16 cycles after a fresh arm
        write_reg(8'h1A);
        write_reg(8'h02);
        check(rd_data, 8'h02, "R6 disarm");
        write_reg(8'h0A);
        for (int k = 1; k <= 16; k++) begin
            step();
            check({7'd0, wdt_rst}, (k == 16) ? 8'h01 : 8'h00, "R9 code2");
        end

        // R10: kick at edge 10 pushes the request to edge 26
        for (int k = 1; k <= 26; k++) begin
            kick = (k == 10);
            step();
            check({7'd0, wdt_rst}, (k == 26) ? 8'h01 : 8'h00, "R10 kick");
        end
        kick = 1'b0;

        // R11: disarmed watchdog stays silent
        write_reg(8'h1A);
        write_reg(8'h02);
        check(rd_data, 8'h02, "R11 disarmed");
        for (int k = 1; k <= 40; k++) begin
            step();
            check({7'd0, wdt_rst}, 8'h00, "R11 quiet");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule